// File: doc/BRIEF.md
# Power-Management I/O Window Decoder with APM Mode Control

This block holds the few configuration bytes that place and switch on a 64-byte power-management I/O window, and it handles writes to the APM command port. Configuration bytes arrive one at a time as byte writes at an 8-bit offset. A combinational read port returns any held byte. The window base comes from the low sixteen bits of a 32-bit little-endian field with the low six bits masked off. The base and the enable take effect together, and only when the enable byte is written.

An APM command byte can turn the ACPI mode bit on or off. Every APM command also raises a one-cycle system-management interrupt pulse, but only when a permission bit in a configuration byte is set. A strap input presets that byte at reset, so the platform can show its SMM handler as already initialised.

Top module: `pmio_pm_decode`

## Requirements
- R1: After reset, offset 0x40 reads 0x01. Offsets 0x41 to 0x43, 0x58 to 0x5a and 0x80 read 0x00. `win_base`, `win_en`, `win_hit`, `acpi_mode` and `smi_pulse` are all 0.
- R2: Bit 0 of offset 0x40 always reads 1, whatever value is written. Bits 7:1 of 0x40, and all bits of 0x41 to 0x43, 0x58 to 0x5b and 0x80, read back the last value written.
- R3: A configuration write to offset 0x80 loads `win_base` with {byte 0x41, byte 0x40} AND 0xffc0. Bytes 0x42 and 0x43 have no effect on it. The same write loads `win_en` with bit 0 of the written data. Both outputs are visible on the clock cycle after the write.
- R4: A write to any offset other than 0x80 leaves `win_base` and `win_en` unchanged.
- R5: `win_hit` is 1 in the same cycle exactly when `win_en` is 1 and `io_addr[15:6]` equals `win_base[15:6]`.
- R6: On the cycle after an APM write, `acpi_mode` is:
  - 1 if the command was 0xf1;
  - 0 if the command was 0xf0;
  - unchanged for any other command.
- R7: `smi_pulse` is 1 for exactly the one cycle after an APM write, and only when bit 1 of offset 0x5b is 1 at the time of that write. Otherwise it stays 0.
- R8: At reset, offset 0x5b reads 0x02 when `smm_ready_strap` is 1 and 0x00 when it is 0.
- R9: Offsets other than 0x40 to 0x43, 0x58 to 0x5b and 0x80 read 0x00. Writes to them change no output and no held byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smm_ready_strap | input | 1 | Presets the SMI-permission byte at reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_addr | input | 8 | Configuration write offset |
| cfg_wr_data | input | 8 | Configuration write data |
| cfg_rd_addr | input | 8 | Configuration read offset |
| cfg_rd_data | output | 8 | Configuration read data (combinational) |
| apm_wr_en | input | 1 | APM command write strobe |
| apm_wr_data | input | 8 | APM command byte |
| io_addr | input | 16 | I/O address to decode |
| win_base | output | 16 | Current window base |
| win_en | output | 1 | Window enabled |
| win_hit | output | 1 | io_addr falls inside the enabled window |
| acpi_mode | output | 1 | ACPI mode (SCI enable) bit |
| smi_pulse | output | 1 | One-cycle system-management interrupt |

## Verification
Each result is due at a fixed time:

| Result | When it is due |
|---|---|
| `cfg_rd_data`, `win_hit` | Same cycle as the input that drives them |
| `win_base`, `win_en`, `acpi_mode`, `smi_pulse` | One clock edge after the accepted write |
| `smi_pulse` low again | One further edge |

The bench drives every input on the falling edge and deasserts the strobe on the next falling edge. It compares the registered results at that second falling edge, and samples `smi_pulse` once more a cycle later to confirm it has dropped. Combinational results are compared one time unit after their inputs settle, with no clock edge in between.

// File: rtl/pmio_pkg.sv
package pmio_pkg;
   typedef logic [7:0] cfg_byte_t;
   localparam cfg_byte_t APM_CMD_ACPI_ON  = 8'hf1;
   localparam cfg_byte_t APM_CMD_ACPI_OFF = 8'hf0;
   localparam cfg_byte_t SMM_DONE_MARK    = 8'h02;
   localparam cfg_byte_t BASE_RO_BITS     = 8'h01;
endpackage

// File: rtl/pmio_cfg_bank.sv
module pmio_cfg_bank
   import pmio_pkg::*;
#(
   parameter int              CFG_AW     = 8,
   parameter logic [CFG_AW-1:0] BASE_OFS = 8'h40,
   parameter logic [CFG_AW-1:0] EN_OFS   = 8'h80,
   parameter logic [CFG_AW-1:0] SCR_OFS  = 8'h58,
   parameter int              BASE_BYTES = 4,
   parameter int              SCR_BYTES  = 4,
   parameter int              SMI_IDX    = 3,
   parameter int              SMI_BIT    = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smm_ready_strap,
   input  logic                    wr_en,
   input  logic [CFG_AW-1:0]       wr_addr,
   input  cfg_byte_t               wr_data,
   input  logic [CFG_AW-1:0]       rd_addr,
   output cfg_byte_t               rd_data,
   output logic [8*BASE_BYTES-1:0] base_raw,
   output logic                    remap,
   output logic                    en_next,
   output logic                    smi_allow
);
   logic [8*SCR_BYTES-1:0] scr_flat;
   cfg_byte_t              en_q;

   if (SMI_IDX >= SCR_BYTES || SMI_BIT > 7) begin : g_bad_smi
      $error("pmio_cfg_bank: SMI permission bit outside the scratch bytes");
   end

   for (genvar i = 0; i < BASE_BYTES; i++) begin : g_base
      localparam cfg_byte_t RO = (i == 0) ? BASE_RO_BITS : 8'h00;
      cfg_byte_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= RO;
         else if (wr_en && wr_addr == BASE_OFS + CFG_AW'(i))
            q <= wr_data | RO;
      end
      assign base_raw[8*i +: 8] = q;
   end

   for (genvar i = 0; i < SCR_BYTES; i++) begin : g_scr
      cfg_byte_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= (i == SMI_IDX && smm_ready_strap) ? SMM_DONE_MARK : 8'h00;
         else if (wr_en && wr_addr == SCR_OFS + CFG_AW'(i))
            q <= wr_data;
      end
      assign scr_flat[8*i +: 8] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= '0;
      else if (remap)
         en_q <= wr_data;
   end

   assign remap     = wr_en && (wr_addr == EN_OFS);
   assign en_next   = wr_data[0];
   assign smi_allow = scr_flat[8*SMI_IDX + SMI_BIT];

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < BASE_BYTES; i++)
         if (rd_addr == BASE_OFS + CFG_AW'(i)) rd_data = base_raw[8*i +: 8];
      for (int i = 0; i < SCR_BYTES; i++)
         if (rd_addr == SCR_OFS + CFG_AW'(i)) rd_data = scr_flat[8*i +: 8];
      if (rd_addr == EN_OFS) rd_data = en_q;
   end
endmodule

// File: rtl/pmio_window.sv
module pmio_window #(
   parameter int IO_AW     = 16,
   parameter int WIN_BYTES = 64,
   parameter int RAW_W     = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RAW_W-1:0] base_raw,
   input  logic             remap,
   input  logic             en_next,
   input  logic [IO_AW-1:0] io_addr,
   output logic [IO_AW-1:0] win_base,
   output logic             win_en,
   output logic             win_hit
);
   localparam int             WIN_LSB = $clog2(WIN_BYTES);
   localparam logic [IO_AW-1:0] MASK  = ~IO_AW'(WIN_BYTES - 1);

   if ((1 << WIN_LSB) != WIN_BYTES || IO_AW > RAW_W || WIN_LSB >= IO_AW) begin : g_bad_geom
      $error("pmio_window: window size must be a power of two inside the address field");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_base <= '0;
         win_en   <= 1'b0;
      end else if (remap) begin
         win_base <= base_raw[IO_AW-1:0] & MASK;
         win_en   <= en_next;
      end
   end

   assign win_hit = win_en && (io_addr[IO_AW-1:WIN_LSB] == win_base[IO_AW-1:WIN_LSB]);
endmodule

// File: rtl/pmio_apm.sv
module pmio_apm
   import pmio_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      apm_wr_en,
   input  cfg_byte_t apm_wr_data,
   input  logic      smi_allow,
   output logic      acpi_mode,
   output logic      smi_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acpi_mode <= 1'b0;
         smi_pulse <= 1'b0;
      end else begin
         smi_pulse <= apm_wr_en && smi_allow;
         if (apm_wr_en) begin
            if (apm_wr_data == APM_CMD_ACPI_ON)       acpi_mode <= 1'b1;
            else if (apm_wr_data == APM_CMD_ACPI_OFF) acpi_mode <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pmio_pm_decode.sv
module pmio_pm_decode
   import pmio_pkg::*;
#(
   parameter int IO_AW      = 16,
   parameter int WIN_BYTES  = 64,
   parameter int BASE_BYTES = 4,
   parameter int SCR_BYTES  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smm_ready_strap,
   input  logic             cfg_wr_en,
   input  logic [7:0]       cfg_wr_addr,
   input  logic [7:0]       cfg_wr_data,
   input  logic [7:0]       cfg_rd_addr,
   output logic [7:0]       cfg_rd_data,
   input  logic             apm_wr_en,
   input  logic [7:0]       apm_wr_data,
   input  logic [IO_AW-1:0] io_addr,
   output logic [IO_AW-1:0] win_base,
   output logic             win_en,
   output logic             win_hit,
   output logic             acpi_mode,
   output logic             smi_pulse
);
   localparam int RAW_W = 8 * BASE_BYTES;

   logic [RAW_W-1:0] base_raw;
   logic             remap, en_next, smi_allow;

   pmio_cfg_bank #(
      .CFG_AW(8), .BASE_BYTES(BASE_BYTES), .SCR_BYTES(SCR_BYTES)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .smm_ready_strap(smm_ready_strap),
      .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
      .rd_addr(cfg_rd_addr), .rd_data(cfg_rd_data),
      .base_raw(base_raw), .remap(remap), .en_next(en_next), .smi_allow(smi_allow)
   );

   pmio_window #(.IO_AW(IO_AW), .WIN_BYTES(WIN_BYTES), .RAW_W(RAW_W)) u_win (
      .clk(clk), .rst_n(rst_n), .base_raw(base_raw), .remap(remap), .en_next(en_next),
      .io_addr(io_addr), .win_base(win_base), .win_en(win_en), .win_hit(win_hit)
   );

   pmio_apm u_apm (
      .clk(clk), .rst_n(rst_n), .apm_wr_en(apm_wr_en), .apm_wr_data(apm_wr_data),
      .smi_allow(smi_allow), .acpi_mode(acpi_mode), .smi_pulse(smi_pulse)
   );
endmodule

// File: rtl/pmio_pm_decode_chk.sv
module pmio_pm_decode_chk
   import pmio_pkg::*;
#(
   parameter int IO_AW = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr_en,
   input logic [7:0]       cfg_wr_addr,
   input logic             apm_wr_en,
   input logic [7:0]       apm_wr_data,
   input logic [IO_AW-1:0] win_base,
   input logic             win_en,
   input logic             win_hit,
   input logic             acpi_mode,
   input logic             smi_pulse,
   input logic             smi_allow
);
   assert_win_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr_en && cfg_wr_addr == 8'h80) |=> $stable(win_base) && $stable(win_en));

   assert_hit_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
      win_hit |-> win_en);

   assert_mode_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
      apm_wr_en && apm_wr_data == APM_CMD_ACPI_ON |=> acpi_mode);

   assert_mode_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      apm_wr_en && apm_wr_data == APM_CMD_ACPI_OFF |=> !acpi_mode);

   assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(apm_wr_en && (apm_wr_data == APM_CMD_ACPI_ON || apm_wr_data == APM_CMD_ACPI_OFF))
      |=> $stable(acpi_mode));

   assert_smi_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
      apm_wr_en && smi_allow |=> smi_pulse);

   assert_smi_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(apm_wr_en && smi_allow) |=> !smi_pulse);
endmodule

bind pmio_pm_decode pmio_pm_decode_chk #(.IO_AW(IO_AW)) u_chk (.*);

// File: tb/tb_pmio_pm_decode.sv
module tb_pmio_pm_decode;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smm_ready_strap = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [7:0]  cfg_wr_addr = '0, cfg_wr_data = '0, cfg_rd_addr = '0;
   logic [7:0]  cfg_rd_data;
   logic        apm_wr_en = 1'b0;
   logic [7:0]  apm_wr_data = '0;
   logic [15:0] io_addr = '0;
   logic [15:0] win_base;
   logic        win_en, win_hit, acpi_mode, smi_pulse;

   int checks = 0, fails = 0;
   logic [7:0]  m [256];
   logic [15:0] e_base;
   logic        e_en, e_mode;

   always #10 clk = ~clk;

   pmio_pm_decode dut (.*);

   function automatic bit held(input logic [7:0] a);
      return (a >= 8'h40 && a <= 8'h43) || (a >= 8'h58 && a <= 8'h5b) || a == 8'h80;
   endfunction

   function automatic logic exp_hit(input logic [15:0] a);
      return e_en && (a[15:6] == e_base[15:6]);
   endfunction

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic model_reset(input logic strap);
      for (int i = 0; i < 256; i++) m[i] = 8'h00;
      m[8'h40] = 8'h01;
      m[8'h5b] = strap ? 8'h02 : 8'h00;
      e_base = '0; e_en = 1'b0; e_mode = 1'b0;
   endtask

   task automatic do_reset(input logic strap);
      @(negedge clk);
      rst_n = 1'b0; smm_ready_strap = strap;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset(strap);
   endtask

   task automatic read_chk(input string req, input logic [7:0] a);
      cfg_rd_addr = a; #1;
      check(req, {8'h00, cfg_rd_data}, {8'h00, m[a]});
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      if (held(a)) m[a] = (a == 8'h40) ? (d | 8'h01) : d;
      if (a == 8'h80) begin
         e_base = {m[8'h41], m[8'h40]} & 16'hffc0;
         e_en = d[0];
      end
      check("R3/R4 win_base", win_base, e_base);
      check("R3/R4 win_en", {15'd0, win_en}, {15'd0, e_en});
      read_chk("R2/R9 readback", a);
   endtask

   task automatic apm_write(input logic [7:0] d);
      logic e_smi;
      e_smi = m[8'h5b][1];
      @(negedge clk);
      apm_wr_en = 1'b1; apm_wr_data = d;
      @(negedge clk);
      apm_wr_en = 1'b0;
      if (d == 8'hf1) e_mode = 1'b1;
      else if (d == 8'hf0) e_mode = 1'b0;
      check("R6 acpi_mode", {15'd0, acpi_mode}, {15'd0, e_mode});
      check("R7 smi_pulse", {15'd0, smi_pulse}, {15'd0, e_smi});
      @(negedge clk);
      check("R7 smi_pulse one cycle", {15'd0, smi_pulse}, 16'd0);
   endtask

   task automatic probe(input logic [15:0] a);
      io_addr = a; #1;
      check("R5 win_hit", {15'd0, win_hit}, {15'd0, exp_hit(a)});
   endtask

   initial begin
      void'($urandom(32'h0000_5eed));
      // R1 reset state, strap low
      do_reset(1'b0);
      #1;
      foreach (m[i]) if (held(8'(i))) read_chk("R1 reset byte", 8'(i));
      check("R1 win_base", win_base, 16'h0000);
      check("R1 win_en", {15'd0, win_en}, 16'd0);
      check("R1 acpi_mode", {15'd0, acpi_mode}, 16'd0);
      check("R1 smi_pulse", {15'd0, smi_pulse}, 16'd0);
      probe(16'h0000);
      read_chk("R8 strap low", 8'h5b);
      apm_write(8'hf1);                   // R7: no SMI without permission
      // R8 strap high
      do_reset(1'b1);
      read_chk("R8 strap high", 8'h5b);
      // R2 read-only bit
      cfg_write(8'h40, 8'h00);
      cfg_write(8'h40, 8'hfe);
      // R4 base bytes alone do not move the window
      cfg_write(8'h41, 8'hb0);
      cfg_write(8'h42, 8'hff);
      cfg_write(8'h43, 8'hff);
      // R3 enable write maps it
      cfg_write(8'h80, 8'h01);
      check("R3 directed base", win_base, 16'hb0c0);
      probe(16'hb0c0); probe(16'hb0ff); probe(16'hb100); probe(16'hb0bf);
      cfg_write(8'h80, 8'h00);            // R3 disable
      probe(16'hb0c5);
      // R9 unheld offsets
      cfg_write(8'h10, 8'hff);
      cfg_write(8'hff, 8'h5a);
      // R6/R7 APM with strap-granted permission
      apm_write(8'hf1); apm_write(8'h33); apm_write(8'hf0); apm_write(8'hf2);
      cfg_write(8'h5b, 8'h00);
      apm_write(8'hf1);
      // random mix
      for (int n = 0; n < 400; n++) begin
         int op;
         op = $urandom_range(0, 2);
         if (op == 0) begin
            logic [7:0] a;
            case ($urandom_range(0, 5))
               0: a = 8'h40;
               1: a = 8'h41;
               2: a = 8'h80;
               3: a = 8'h5b;
               4: a = 8'h58 + 8'($urandom_range(0, 2));
               default: a = 8'($urandom);
            endcase
            cfg_write(a, 8'($urandom));
         end else if (op == 1) begin
            logic [7:0] d;
            case ($urandom_range(0, 2))
               0: d = 8'hf0;
               1: d = 8'hf1;
               default: d = 8'($urandom);
            endcase
            apm_write(d);
         end else begin
            if ($urandom_range(0, 1) == 1) probe(e_base | 16'($urandom_range(0, 63)));
            else probe(16'($urandom));
         end
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule